// File: doc/BRIEF.md
# Ternary CAM lookup engine

A small content-addressable table of 64-bit words that a packet controller uses to turn a header address into a table index. Entries are loaded through a 32-bit command port in two halves. A single command then searches every valid entry at once and returns the lowest matching index, with a hit flag and a flag for more than one hit. The search takes the same time whatever the table holds and wherever the hit sits. The index is meant to address a side RAM that holds forwarding data.

A word can hold a 64-bit exact key, such as a MAC address, or 32 ternary digits for prefix routing. Ternary digit n is kept as a bit pair 32 positions apart. The digit value goes in bit n and its complement in bit n+32. A pair of two zeros is a don't-care. Longer prefixes are loaded at lower indices, so the lowest-index hit is the longest matching prefix.

Each entry has a validity bit. It is set when the high half is written, and cleared by index or by an associative search. Every index that a write or delete touches is reported on an address output for one cycle, so the side RAM can be kept in step. A full flag shows that every entry is valid.

Top module: `tern_cam`

## Requirements
- R1: After reset no entry is valid, full_o is 0, res_match_o and res_multi_o are 0, res_idx_o is 0 and addr_vld_o is 0.
- R2: Op 1 (load low) only latches cmd_data_i as the staged low half; it validates nothing and gives no address pulse. Op 2 (write high) stores {cmd_data_i, staged low} at cmd_idx_i and sets that entry valid. In the next cycle it drives addr_o = cmd_idx_i with addr_vld_o = 1 for one cycle.
- R3: Op 4 (ternary compare) with input D hits an entry when, for every n in 0..31, D[n]=1 finds bit n+32 at 0 and D[n]=0 finds bit n at 0. So a stored 0 (bit n=0, bit n+32=1) matches only 0, a stored 1 (1,0) matches only 1, a don't-care (0,0) matches both, and a pair (1,1) matches nothing.
- R4: Op 3 (binary compare) hits only an entry equal in all 64 bits to {cmd_data_i, staged low}.
- R5: On several hits res_idx_o is the lowest hitting index and res_multi_o is 1. On exactly one hit res_multi_o is 0.
- R6: An invalid entry never hits in any compare or associative delete.
- R7: Compare results appear in the cycle after the compare command and then hold unchanged until the next compare. Writes and deletes issued after a compare do not alter its result.
- R8: Op 5 (delete by index) clears the validity of cmd_idx_i. In the next cycle it pulses addr_vld_o with addr_o = cmd_idx_i.
- R9: Op 6 (ternary delete) and op 7 (binary delete) use the same match rules as ops 4 and 3. They clear only the lowest hitting entry and pulse addr_vld_o with its index. On no hit they change nothing and give no pulse.
- R10: full_o is 1 exactly when every entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command accepted this cycle |
| cmd_op_i | input | 3 | Opcode 0..7 |
| cmd_idx_i | input | IW | Entry index for writes and index deletes |
| cmd_data_i | input | 32 | Half-word, ternary input or high key half |
| res_idx_o | output | IW | Lowest hitting index of the last compare |
| res_match_o | output | 1 | Last compare hit at least one entry |
| res_multi_o | output | 1 | Last compare hit two or more entries |
| addr_o | output | IW | Index touched by the last write or delete |
| addr_vld_o | output | 1 | One-cycle strobe for addr_o |
| full_o | output | 1 | All entries valid |

## Verification
The bench builds the engine with DEPTH = 8, so every entry can be loaded in a few dozen cycles. This lets the full flag be seen both rising and falling. With this depth, prefix priority across three overlapping entries is also easy to reach, along with a pair holding two ones and deletes that hit or miss. The default depth of 64 uses the same per-entry generate structure and is only elaborated.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_LOAD_LO = 3'd1,
    OP_WRITE   = 3'd2,
    OP_CMP_BIN = 3'd3,
    OP_CMP_TER = 3'd4,
    OP_DEL_IDX = 3'd5,
    OP_DEL_TER = 3'd6,
    OP_DEL_BIN = 3'd7
  } tcam_op_e;

  typedef enum logic {
    MODE_BIN = 1'b0,
    MODE_TER = 1'b1
  } tcam_mode_e;
endpackage

// File: rtl/tcam_store.sv
module tcam_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  parameter int IW    = 6,
  localparam int EW   = 2 * DW
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       lo_en_i,
  input  logic [DW-1:0]              lo_data_i,
  input  logic                       wr_en_i,
  input  logic [IW-1:0]              wr_idx_i,
  input  logic [DW-1:0]              wr_hi_i,
  input  logic                       clr_en_i,
  input  logic [IW-1:0]              clr_idx_i,
  output logic [DW-1:0]              stage_o,
  output logic [DEPTH-1:0][EW-1:0]   ent_o,
  output logic [DEPTH-1:0]           vld_o
);

  logic [DW-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stage_q <= '0;
    else if (lo_en_i) stage_q <= lo_data_i;
  end
  assign stage_o = stage_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic wr_hit, clr_hit;
    assign wr_hit  = wr_en_i  && (wr_idx_i  == IW'(g));
    assign clr_hit = clr_en_i && (clr_idx_i == IW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_o[g] <= '0;
        vld_o[g] <= 1'b0;
      end else begin
        if (wr_hit) ent_o[g] <= {wr_hi_i, stage_q};
        if (wr_hit)       vld_o[g] <= 1'b1;
        else if (clr_hit) vld_o[g] <= 1'b0;
      end
    end
  end

  a_r2_valid_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (int'(wr_idx_i) < DEPTH)) |=> vld_o[$past(wr_idx_i)]);

  a_r8_cleared_after_delete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !wr_en_i && (int'(clr_idx_i) < DEPTH)) |=> !vld_o[$past(clr_idx_i)]);

endmodule

// File: rtl/tcam_match.sv
module tcam_match
  import tcam_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int EW   = 2 * DW
) (
  input  tcam_mode_e                 mode_i,
  input  logic [DW-1:0]              din_i,
  input  logic [EW-1:0]              key_i,
  input  logic [DEPTH-1:0][EW-1:0]   ent_i,
  input  logic [DEPTH-1:0]           vld_i,
  output logic [DEPTH-1:0]           hit_o
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [DW-1:0] lo, hi, miss;
    logic          ter_hit, bin_hit;
    assign lo   = ent_i[g][DW-1:0];
    assign hi   = ent_i[g][EW-1:DW];
    // input 1 needs complement bit clear, input 0 needs value bit clear
    assign miss = (din_i & hi) | (~din_i & lo);
    assign ter_hit = ~|miss;
    assign bin_hit = (ent_i[g] == key_i);
    assign hit_o[g] = vld_i[g] && ((mode_i == MODE_TER) ? ter_hit : bin_hit);
  end

endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int DEPTH = 64,
  parameter int IW    = 6
) (
  input  logic [DEPTH-1:0] vec_i,
  output logic [IW-1:0]    idx_o,
  output logic             any_o,
  output logic             multi_o
);

  always_comb begin
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o   = |vec_i;
  assign multi_o = |(vec_i & (vec_i - DEPTH'(1)));

  always_comb begin
    a_r5_idx_is_hit: assert (!any_o || vec_i[idx_o]);
  end

endmodule

// File: rtl/tern_cam.sv
module tern_cam
  import tcam_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int EW   = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_op_i,
  input  logic [IW-1:0] cmd_idx_i,
  input  logic [DW-1:0] cmd_data_i,
  output logic [IW-1:0] res_idx_o,
  output logic          res_match_o,
  output logic          res_multi_o,
  output logic [IW-1:0] addr_o,
  output logic          addr_vld_o,
  output logic          full_o
);

  tcam_op_e   op;
  tcam_mode_e mode;
  logic       cmp_acc, del_assoc, lo_en, wr_en, clr_en;
  logic [IW-1:0] clr_idx, first_idx;
  logic          any_hit, multi_hit;
  logic [DW-1:0] stage;
  logic [DEPTH-1:0][EW-1:0] ent;
  logic [DEPTH-1:0] vld, hit;

  assign op   = tcam_op_e'(cmd_op_i);
  assign mode = (op == OP_CMP_TER || op == OP_DEL_TER) ? MODE_TER : MODE_BIN;

  assign cmp_acc   = cmd_valid_i && (op == OP_CMP_BIN || op == OP_CMP_TER);
  assign del_assoc = cmd_valid_i && (op == OP_DEL_BIN || op == OP_DEL_TER);
  assign lo_en     = cmd_valid_i && (op == OP_LOAD_LO);
  assign wr_en     = cmd_valid_i && (op == OP_WRITE);
  assign clr_en    = (cmd_valid_i && op == OP_DEL_IDX) || (del_assoc && any_hit);
  assign clr_idx   = (op == OP_DEL_IDX) ? cmd_idx_i : first_idx;

  tcam_store #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lo_en_i   (lo_en),
    .lo_data_i (cmd_data_i),
    .wr_en_i   (wr_en),
    .wr_idx_i  (cmd_idx_i),
    .wr_hi_i   (cmd_data_i),
    .clr_en_i  (clr_en),
    .clr_idx_i (clr_idx),
    .stage_o   (stage),
    .ent_o     (ent),
    .vld_o     (vld)
  );

  tcam_match #(.DEPTH(DEPTH), .DW(DW)) u_match (
    .mode_i (mode),
    .din_i  (cmd_data_i),
    .key_i  ({cmd_data_i, stage}),
    .ent_i  (ent),
    .vld_i  (vld),
    .hit_o  (hit)
  );

  tcam_prio #(.DEPTH(DEPTH), .IW(IW)) u_prio (
    .vec_i   (hit),
    .idx_o   (first_idx),
    .any_o   (any_hit),
    .multi_o (multi_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_idx_o   <= '0;
      res_match_o <= 1'b0;
      res_multi_o <= 1'b0;
    end else if (cmp_acc) begin
      res_idx_o   <= first_idx;
      res_match_o <= any_hit;
      res_multi_o <= multi_hit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      addr_vld_o <= 1'b0;
    end else begin
      addr_vld_o <= wr_en || clr_en;
      if (wr_en)       addr_o <= cmd_idx_i;
      else if (clr_en) addr_o <= clr_idx;
    end
  end

  assign full_o = &vld;

  a_r5_multi_needs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_multi_o |-> res_match_o);

  a_r7_result_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cmp_acc) |-> ($stable(res_idx_o) && $stable(res_match_o) && $stable(res_multi_o)));

  a_r9_strobe_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |-> $past(cmd_valid_i));

  a_r10_full_rises_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(wr_en));

endmodule

// File: tb/sim_tern_cam.sv
`timescale 1ns/1ps
module sim_tern_cam;
  localparam int DEPTH = 8;
  localparam int IW    = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic [2:0]    cmd_op_i = '0;
  logic [IW-1:0] cmd_idx_i = '0;
  logic [31:0]   cmd_data_i = '0;
  logic [IW-1:0] res_idx_o, addr_o;
  logic          res_match_o, res_multi_o, addr_vld_o, full_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  tern_cam #(.DEPTH(DEPTH), .DW(32)) u0 (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_idx_i, .cmd_data_i,
    .res_idx_o, .res_match_o, .res_multi_o, .addr_o, .addr_vld_o, .full_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_res(input string req, input bit m, input int idx, input bit mu);
    chk(res_match_o == m, req, "match", longint'(res_match_o), longint'(m));
    if (m) chk(res_idx_o == IW'(idx), req, "index", longint'(res_idx_o), longint'(idx));
    chk(res_multi_o == mu, req, "multi", longint'(res_multi_o), longint'(mu));
  endtask

  task automatic expect_addr(input string req, input bit v, input int idx);
    chk(addr_vld_o == v, req, "addr_vld", longint'(addr_vld_o), longint'(v));
    if (v) chk(addr_o == IW'(idx), req, "addr", longint'(addr_o), longint'(idx));
  endtask

  // drive at negedge, return at the next negedge with results visible
  task automatic cmd(input int op, input int idx, input logic [31:0] d);
    cmd_valid_i = 1'b1;
    cmd_op_i    = 3'(op);
    cmd_idx_i   = IW'(idx);
    cmd_data_i  = d;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic wr_entry(input int idx, input logic [63:0] v);
    cmd(1, 0, v[31:0]);
    cmd(2, idx, v[63:32]);
  endtask

  function automatic logic [63:0] tern(input logic [31:0] val, input logic [31:0] care);
    return {~val & care, val & care};
  endfunction

  task automatic t_reset();
    expect_res("R1", 1'b0, 0, 1'b0);
    chk(res_idx_o == '0, "R1", "idx", longint'(res_idx_o), 0);
    expect_addr("R1", 1'b0, 0);
    chk(full_o == 1'b0, "R1", "full", longint'(full_o), 0);
    cmd(4, 0, 32'h0);
    expect_res("R6", 1'b0, 0, 1'b0);
  endtask

  task automatic t_write();
    logic [63:0] v = tern(32'hC0A8_0000, 32'hFFFF_0000);
    cmd(1, 0, v[31:0]);
    expect_addr("R2", 1'b0, 0);
    cmd(4, 0, 32'hC0A8_0105);
    expect_res("R2", 1'b0, 0, 1'b0);
    cmd(2, 2, v[63:32]);
    expect_addr("R2", 1'b1, 2);
    cmd(4, 0, 32'hC0A8_0105);
    expect_res("R3", 1'b1, 2, 1'b0);
    cmd(4, 0, 32'hC0A9_0105);
    expect_res("R3", 1'b0, 0, 1'b0);
  endtask

  task automatic t_prio();
    wr_entry(1, tern(32'hC0A8_0100, 32'hFFFF_FF00));
    wr_entry(5, tern(32'h0, 32'h0));
    cmd(4, 0, 32'hC0A8_0105);
    expect_res("R5", 1'b1, 1, 1'b1);
    cmd(4, 0, 32'h0A00_0001);
    expect_res("R5", 1'b1, 5, 1'b0);
    cmd(4, 0, 32'hC0A8_0205);
    expect_res("R5", 1'b1, 2, 1'b1);
    wr_entry(3, 64'hFFFF_FFFF_FFFF_FFFF);
    cmd(4, 0, 32'hFFFF_FFFF);
    expect_res("R3", 1'b1, 5, 1'b0);
  endtask

  task automatic t_binary();
    wr_entry(0, 64'h0011_2233_4455_6677);
    cmd(1, 0, 32'h4455_6677);
    cmd(3, 0, 32'h0011_2233);
    expect_res("R4", 1'b1, 0, 1'b0);
    cmd(1, 0, 32'h4455_6676);
    cmd(3, 0, 32'h0011_2233);
    expect_res("R4", 1'b0, 0, 1'b0);
    cmd(1, 0, 32'h4455_6677);
    cmd(3, 0, 32'h0011_2233);
    expect_res("R4", 1'b1, 0, 1'b0);
    cmd(5, 0, 32'h0);
    expect_res("R7", 1'b1, 0, 1'b0);
    expect_addr("R8", 1'b1, 0);
    cmd(0, 0, 32'h0);
    expect_addr("R8", 1'b0, 0);
    expect_res("R7", 1'b1, 0, 1'b0);
    cmd(3, 0, 32'h0011_2233);
    expect_res("R6", 1'b0, 0, 1'b0);
  endtask

  task automatic t_assoc_del();
    cmd(6, 0, 32'hC0A8_0105);
    expect_addr("R9", 1'b1, 1);
    cmd(4, 0, 32'hC0A8_0105);
    expect_res("R9", 1'b1, 2, 1'b1);
    cmd(7, 0, 32'hDEAD_BEEF);
    expect_addr("R9", 1'b0, 0);
    cmd(4, 0, 32'hC0A8_0105);
    expect_res("R9", 1'b1, 2, 1'b1);
    cmd(1, 0, 32'hFFFF_FFFF);
    cmd(7, 0, 32'hFFFF_FFFF);
    expect_addr("R9", 1'b1, 3);
    cmd(3, 0, 32'hFFFF_FFFF);
    expect_res("R9", 1'b0, 0, 1'b0);
  endtask

  task automatic t_full();
    // valid now: 2 and 5
    wr_entry(0, 64'hFFFF_FFFF_FFFF_FFFF);
    wr_entry(1, 64'hFFFF_FFFF_FFFF_FFFF);
    wr_entry(3, 64'hFFFF_FFFF_FFFF_FFFF);
    wr_entry(4, 64'hFFFF_FFFF_FFFF_FFFF);
    wr_entry(6, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(full_o == 1'b0, "R10", "full early", longint'(full_o), 0);
    wr_entry(7, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(full_o == 1'b1, "R10", "full set", longint'(full_o), 1);
    cmd(5, 4, 32'h0);
    chk(full_o == 1'b0, "R10", "full clear", longint'(full_o), 0);
    expect_addr("R8", 1'b1, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset_pre();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_write();
    t_prio();
    t_binary();
    t_assoc_del();
    t_full();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic t_reset_pre();
    chk(addr_vld_o == 1'b0, "R1", "addr_vld in reset", longint'(addr_vld_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule